// File: doc/BRIEF.md
# Buffered Bidirectional Synchronous Serial Port

This block is a byte-wide synchronous serial port. A data register sits in front of a shift register. A single mode input picks the direction. In receive mode, an external shift clock arrives on a pin. The block brings that clock and the data pin into the system clock domain, then shifts in one bit on each rising edge it detects. After every eighth bit, the received byte is placed in the data register and a one-cycle interrupt pulse is raised.

In transmit mode, the port drives the shift clock itself. It uses an underflow strobe from an external timer, and every strobe toggles the clock pin, so one bit spans two strobes. A byte starts only after a write to the data register, and only while the timer reports that it is running continuously. A write that arrives before the current byte's eighth clock is chained straight on with no idle gap. With nothing pending, the clock parks high and the data pin keeps the last bit sent. Each pin is modelled as separate in, out and enable signals, so both lines can be shared on a bus with one master.

Top module: `sync_serial_port`

## Requirements
- R1: After reset: `sclk_oe` and `sdat_oe` are 0, `sclk_o` and `sdat_o` are 1, `rd_data` is 0 and `irq` is 0. One cycle after `mode_tx` is sampled, both enables equal `mode_tx` (1 = transmit, 0 = receive), and in receive mode `sclk_o` is 1.
- R2: Bits are shifted most significant bit first in both directions.
- R3: In receive mode, `sdat_i` is sampled on each rising edge of `sclk_i`. Detection runs through a two-flop synchroniser plus an edge flop, so the shift takes effect three clock edges after the pin change. On the eighth edge, `rd_data` takes the received byte.
- R4: In transmit mode, `sclk_o` changes only on a cycle after an asserted `tmr_uflow`, while a byte is in flight. Each bit lasts exactly two underflows.
- R5: A transfer starts only when a write is pending and `tmr_cont_run` is 1. With `tmr_cont_run` at 0, `sclk_o` stays 1 and no bits leave.
- R6: `sdat_o` takes a new bit only when `sclk_o` falls, and it holds that bit through the following rise.
- R7: A byte written before the eighth rising clock of the current byte follows on with no gap. Consecutive interrupts in such a chain are 2x8 underflows apart.
- R8: With nothing pending after the eighth rising clock, `sclk_o` stays 1 and `sdat_o` keeps the last bit transmitted.
- R9: `irq` is a single-cycle pulse. In transmit mode it appears in the same cycle that `sclk_o` returns high after the eighth bit. In receive mode it appears in the same cycle that `rd_data` shows the byte.
- R10: A write in the very cycle that a pending byte moves to the shift register does not disturb the moving byte: the moving byte is the one written earlier, and the new byte stays pending and is sent next. In receive mode, a received byte overrides a write to the data register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tx | input | 1 | 1 = transmit mode, 0 = receive mode |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Data register write value |
| rd_data | output | 8 | Data register contents |
| tmr_uflow | input | 1 | One-cycle timer underflow strobe |
| tmr_cont_run | input | 1 | Timer is running in continuous mode |
| sclk_i | input | 1 | Shift clock pin input |
| sclk_o | output | 1 | Shift clock pin output value |
| sclk_oe | output | 1 | Shift clock pin output enable |
| sdat_i | input | 1 | Serial data pin input |
| sdat_o | output | 1 | Serial data pin output value |
| sdat_oe | output | 1 | Serial data pin output enable |
| irq | output | 1 | One-cycle byte-complete interrupt |

## Verification
Two functions can fall in one cycle: a register write and the move of a byte, either into the shift register at the eighth transmit clock or, in receive mode, from the shift register into the data register. The bench provokes each case by watching its reference model and raising `wr_en` in the exact cycle the move happens. The transmit case is judged by the order of bytes recovered from the pins. The receive case is judged by which value `rd_data` holds afterwards. A behavioural model built from bit queues is compared against every output on every clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_HIGH = 2'd1,
    TXS_LOW  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_pin,
  input  logic sdat_pin,
  output logic rise,
  output logic sdat_s
);
  logic [STAGES-1:0] ck_sr;
  logic [STAGES-1:0] dt_sr;
  logic              ck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sr   <= '1;
      dt_sr   <= '0;
      ck_last <= 1'b1;
    end else begin
      ck_sr   <= {ck_sr[STAGES-2:0], sclk_pin};
      dt_sr   <= {dt_sr[STAGES-2:0], sdat_pin};
      ck_last <= ck_sr[STAGES-1];
    end
  end

  assign rise   = ck_sr[STAGES-1] & ~ck_last;
  assign sdat_s = dt_sr[STAGES-1];
endmodule

// File: rtl/ssp_rx_engine.sv
module ssp_rx_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rise,
  input  logic          din,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (rise) begin
      sh <= {sh[DW-2:0], din};
      if (cnt == CW'(DW-1)) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end

  assign done    = en & rise & (cnt == CW'(DW-1));
  assign rx_word = {sh[DW-2:0], din};
endmodule

// File: rtl/ssp_tx_engine.sv
module ssp_tx_engine
  import ssp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          run,
  input  logic          uflow,
  input  logic          pend,
  input  logic [DW-1:0] dreg,
  output logic          take,
  output logic          done,
  output logic          sclk_o,
  output logic          sdat_o
);
  localparam int CW = $clog2(DW);

  tx_state_e     st;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          last_rise;

  assign last_rise = (st == TXS_LOW) & uflow & (cnt == CW'(DW-1));
  assign take      = en & pend & (((st == TXS_IDLE) & run) | last_rise);
  assign done      = en & last_rise;
  assign sclk_o    = (st != TXS_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TXS_IDLE;
      sh     <= '0;
      cnt    <= '0;
      sdat_o <= 1'b1;
    end else if (!en) begin
      st  <= TXS_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        TXS_IDLE: begin
          if (take) begin
            sh  <= dreg;
            cnt <= '0;
            st  <= TXS_HIGH;
          end
        end
        TXS_HIGH: begin
          if (uflow) begin
            sdat_o <= sh[DW-1];
            sh     <= {sh[DW-2:0], 1'b0};
            st     <= TXS_LOW;
          end
        end
        TXS_LOW: begin
          if (uflow) begin
            if (cnt == CW'(DW-1)) begin
              if (take) begin
                sh  <= dreg;
                cnt <= '0;
                st  <= TXS_HIGH;
              end else begin
                st <= TXS_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
              st  <= TXS_HIGH;
            end
          end
        end
        default: st <= TXS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_tx,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          tmr_uflow,
  input  logic          tmr_cont_run,
  input  logic          sclk_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          sdat_i,
  output logic          sdat_o,
  output logic          sdat_oe,
  output logic          irq
);
  logic [DW-1:0] dreg;
  logic          pend;
  logic          oe_q;
  logic          irq_q;
  logic          rise;
  logic          sdat_s;
  logic          rx_done;
  logic [DW-1:0] rx_word;
  logic          tx_take;
  logic          tx_done;

  ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sclk_pin (sclk_i),
    .sdat_pin (sdat_i),
    .rise     (rise),
    .sdat_s   (sdat_s)
  );

  ssp_rx_engine #(.DW(DW)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .en      (~mode_tx),
    .rise    (rise),
    .din     (sdat_s),
    .done    (rx_done),
    .rx_word (rx_word)
  );

  ssp_tx_engine #(.DW(DW)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .en     (mode_tx),
    .run    (tmr_cont_run),
    .uflow  (tmr_uflow),
    .pend   (pend),
    .dreg   (dreg),
    .take   (tx_take),
    .done   (tx_done),
    .sclk_o (sclk_o),
    .sdat_o (sdat_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dreg  <= '0;
      pend  <= 1'b0;
      oe_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      oe_q  <= mode_tx;
      irq_q <= tx_done | rx_done;
      if (rx_done)    dreg <= rx_word;
      else if (wr_en) dreg <= wr_data;
      if (wr_en)        pend <= 1'b1;
      else if (tx_take) pend <= 1'b0;
    end
  end

  assign rd_data = dreg;
  assign sclk_oe = oe_q;
  assign sdat_oe = oe_q;
  assign irq     = irq_q;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rst,
  input logic mode_tx,
  input logic tmr_uflow,
  input logic irq,
  input logic sclk_o,
  input logic sclk_oe,
  input logic sdat_o
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R9

  AST_OE_TRACKS_MODE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sclk_oe == $past(mode_tx))); // R1

  AST_RX_CLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    !sclk_oe |-> sclk_o); // R1

  AST_CLK_ON_UFLOW: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && $past(sclk_oe) && !$past(tmr_uflow)) |-> $stable(sclk_o)); // R4

  AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && $rose(sclk_o)) |-> $stable(sdat_o)); // R6
endmodule

bind sync_serial_port ssp_checker u_chk (.*);

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
  localparam int DW = 8;
  localparam int UP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_tx = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic tmr_uflow = 1'b0;
  logic tmr_cont_run = 1'b0;
  logic sclk_i = 1'b1;
  logic sclk_o, sclk_oe;
  logic sdat_i = 1'b0;
  logic sdat_o, sdat_oe;
  logic irq;

  always #4 clk = ~clk;

  sync_serial_port #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .mode_tx(mode_tx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tmr_uflow(tmr_uflow), .tmr_cont_run(tmr_cont_run),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  logic [DW-1:0] m_dreg;
  bit m_pend, m_busy, m_sclk, m_sdat, m_irq, m_oe;
  bit h1, h2, h3, d1, d2;
  bit mq[$];
  bit rq[$];
  bit t_take, t_dump, t_irq, t_rise;
  logic [DW-1:0] t_old, t_rx;
  longint cyc = 0;

  task automatic load_bits(input logic [DW-1:0] v);
    mq.delete();
    for (int i = DW - 1; i >= 0; i--) mq.push_back(v[i]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_dreg = '0; m_pend = 0; m_busy = 0; m_sclk = 1; m_sdat = 1;
      m_irq = 0; m_oe = 0; h1 = 1; h2 = 1; h3 = 1; d1 = 0; d2 = 0;
      mq.delete(); rq.delete();
    end else begin
      t_take = 0; t_dump = 0; t_irq = 0; t_old = m_dreg; t_rise = h2 && !h3;
      if (mode_tx) begin
        if (!m_busy) begin
          if (m_pend && tmr_cont_run) begin
            load_bits(t_old); t_take = 1; m_busy = 1;
          end
        end else if (tmr_uflow) begin
          if (m_sclk) begin
            m_sclk = 0; m_sdat = mq.pop_front();
          end else begin
            m_sclk = 1;
            if (mq.size() == 0) begin
              t_irq = 1;
              if (m_pend) begin load_bits(t_old); t_take = 1; end
              else m_busy = 0;
            end
          end
        end
        rq.delete();
      end else begin
        m_busy = 0; m_sclk = 1; mq.delete();
        if (t_rise) begin
          rq.push_back(d2);
          if (rq.size() == DW) begin
            for (int i = 0; i < DW; i++) t_rx[DW-1-i] = rq[i];
            t_dump = 1; t_irq = 1; rq.delete();
          end
        end
      end
      if (wr_en) m_pend = 1; else if (t_take) m_pend = 0;
      if (t_dump) m_dreg = t_rx; else if (wr_en) m_dreg = wr_data;
      m_irq = t_irq; m_oe = mode_tx;
      h3 = h2; h2 = h1; h1 = sclk_i; d2 = d1; d1 = sdat_i;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check(sclk_o == m_sclk, "R4 sclk_o", sclk_o, m_sclk);
      check(sdat_o == m_sdat, "R6 sdat_o", sdat_o, m_sdat);
      check(irq == m_irq, "R9 irq", irq, m_irq);
      check(rd_data == m_dreg, "R3 rd_data", rd_data, m_dreg);
      check(sclk_oe == m_oe && sdat_oe == m_oe, "R1 enables", sclk_oe, m_oe);
    end
  end

  // timer underflow source
  bit uf_en = 0;
  int ufc = 0;
  always @(negedge clk) begin
    if (uf_en) begin
      if (ufc == UP - 1) begin tmr_uflow = 1; ufc = 0; end
      else begin tmr_uflow = 0; ufc++; end
    end else begin
      tmr_uflow = 0; ufc = 0;
    end
  end

  // byte recovery from the transmit pins
  logic [DW-1:0] acc = '0;
  int nb = 0;
  bit prev_sclk = 1;
  logic [DW-1:0] got_q[$];
  always @(negedge clk) begin
    if (rst || !sclk_oe) begin
      nb = 0;
    end else if (sclk_o && !prev_sclk) begin
      acc = {acc[DW-2:0], sdat_o};
      nb++;
      if (nb == DW) begin got_q.push_back(acc); nb = 0; end
    end
    prev_sclk = sclk_o;
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [DW-1:0] v);
    @(negedge clk); #1;
    wr_en = 1; wr_data = v;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic wait_irq(output longint at);
    int guard = 0;
    at = 0;
    do begin @(negedge clk); guard++; end while (!irq && guard < 5000);
    at = cyc;
  endtask

  task automatic rx_bit(input bit b, input bit last, input bit coll, input logic [DW-1:0] cv);
    @(negedge clk); #1;
    sdat_i = b; sclk_i = 0;
    wait_cycles(3); #1;
    sclk_i = 1;
    if (last && coll) begin
      int guard = 0;
      forever begin
        @(negedge clk); #2;
        guard++;
        if ((rq.size() == DW - 1 && h2 && !h3) || guard > 20) break;
      end
      wr_en = 1; wr_data = cv;
      @(negedge clk); #1;
      wr_en = 0;
    end
    wait_cycles(4);
  endtask

  task automatic rx_send(input logic [DW-1:0] v, input bit coll, input logic [DW-1:0] cv);
    for (int i = DW - 1; i >= 0; i--) rx_bit(v[i], i == 0, coll, cv);
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint t1, t2, t3;
    wait_cycles(3);
    // R1 reset state
    check(sclk_oe == 0 && sdat_oe == 0, "R1 reset enables", sclk_oe, 0);
    check(sclk_o == 1 && sdat_o == 1, "R1 reset pins", {sclk_o, sdat_o}, 3);
    check(rd_data == 0 && irq == 0, "R1 reset data/irq", rd_data, 0);
    @(negedge clk); #1; rst = 0;
    wait_cycles(2);

    // R3 R2 receive a byte MSB first
    rx_send(8'hA5, 0, 8'h00);
    check(rd_data == 8'hA5, "R3 received byte", rd_data, 8'hA5);
    check(sclk_oe == 0, "R1 receive enables low", sclk_oe, 0);
    rx_send(8'h81, 0, 8'h00);
    check(rd_data == 8'h81, "R2 MSB-first receive", rd_data, 8'h81);

    // R10 receive dump beats same-cycle write
    rx_send(8'h5A, 1, 8'h3C);
    check(rd_data == 8'h5A, "R10 dump over write", rd_data, 8'h5A);

    // R5 no start without running timer
    @(negedge clk); #1; mode_tx = 1; tmr_cont_run = 0; uf_en = 1;
    do_write(8'hC2);
    got_q.delete();
    wait_cycles(40);
    check(sclk_o == 1 && got_q.size() == 0, "R5 held while timer stopped", got_q.size(), 0);
    check(sclk_oe == 1 && sdat_oe == 1, "R1 transmit enables", sclk_oe, 1);
    @(negedge clk); #1; tmr_cont_run = 1;
    wait_irq(t1);
    wait_cycles(20);
    check(got_q.size() == 1 && got_q[0] == 8'hC2, "R2 transmitted byte",
          got_q.size() ? got_q[0] : 0, 8'hC2);
    check(sclk_o == 1, "R8 clock parked high", sclk_o, 1);
    check(sdat_o == 0, "R8 data holds last bit", sdat_o, 0);

    // R7 chaining with no gap
    got_q.delete();
    do_write(8'h96);
    wait_cycles(3);
    do_write(8'h4B);
    wait_irq(t1);
    wait_irq(t2);
    check(t2 - t1 == 2 * DW * UP, "R7 irq spacing", int'(t2 - t1), 2 * DW * UP);
    wait_cycles(20);
    check(got_q.size() == 2 && got_q[0] == 8'h96 && got_q[1] == 8'h4B, "R7 chained bytes",
          got_q.size(), 2);

    // R10 write in the transfer cycle
    got_q.delete();
    do_write(8'h11);
    wait_cycles(3);
    do_write(8'h22);
    begin
      int guard = 0;
      forever begin
        @(negedge clk); #2;
        guard++;
        if ((m_busy && !m_sclk && mq.size() == 0 && tmr_uflow) || guard > 500) break;
      end
    end
    wr_en = 1; wr_data = 8'h33;
    @(negedge clk); #1; wr_en = 0;
    wait_irq(t1);
    wait_irq(t3);
    wait_cycles(20);
    check(got_q.size() == 3, "R10 byte count", got_q.size(), 3);
    check(got_q.size() == 3 && got_q[1] == 8'h22 && got_q[2] == 8'h33, "R10 byte order",
          got_q.size() == 3 ? got_q[2] : 0, 8'h33);

    wait_cycles(5);
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule